// File: doc/BRIEF.md
# Binarized XNOR-Popcount Neuron

This block produces one output-channel value of a binarized convolution or fully-connected layer. Each input beat carries a packed vector of N binary activations and a packed vector of N binary weights, both using bit 1 to mean +1 and bit 0 to mean -1. The element-wise products are formed with XNOR gates. The ones in the XNOR result are counted, and the count is mapped back to the signed sum of the ±1 products as 2·count − N.

A per-channel signed fixed-point constant (the layer bias with the normalisation mean already folded in) is added to the sum. The integer sum is aligned to the constant's FRAC_W fractional bits before the addition. The block presents the signed fixed-point result and a one-bit binarized activation for the next layer. The count is split into a registered per-chunk stage and a registered total stage, so a new vector may enter on every cycle. Each result appears a fixed three cycles after its input.

Top module: `xnor_popcount_neuron`

## Requirements
- R1: For every accepted beat, `sum_o` (two's complement) equals (Σ p_i)·2^FRAC_W + bias. Here p_i = +1 when `act_i[i]` equals `wgt_i[i]` and −1 otherwise, and `bias_i` is read as a signed value with FRAC_W fractional bits.
- R2: When every activation bit agrees with its weight bit (for example, both vectors all ones or both all zeros), the integer part of the result is +N.
- R3: When every activation bit disagrees with its weight bit, the integer part of the result is −N.
- R4: `bias_i` is sign-extended before the addition, so a negative constant lowers the result, and its low FRAC_W bits appear unchanged in the low bits of `sum_o`.
- R5: `act_o` is 1 when the signed `sum_o` is greater than or equal to zero (zero included), and 0 when it is negative.
- R6: `valid_o` rises exactly three clock cycles after the cycle in which `valid_i` is sampled high. Back-to-back beats produce back-to-back results in order.
- R7: While `rst_n` is low, and after it is released, `valid_o`, `sum_o` and `act_o` are all zero.
- R8: Cycles with `valid_i` low produce no result. `sum_o` and `act_o` keep the last result even if `act_i`, `wgt_i` and `bias_i` change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Marks a beat to be processed |
| act_i | input | N | Packed binary activations (1 = +1, 0 = −1) |
| wgt_i | input | N | Packed binary weights (1 = +1, 0 = −1) |
| bias_i | input | BIAS_W | Signed per-channel constant, FRAC_W fractional bits |
| valid_o | output | 1 | Result strobe |
| sum_o | output | OUT_W | Signed fixed-point result |
| act_o | output | 1 | Binarized activation of the result |

## Verification
On every cycle, the bound checker enforces four properties. The result must lie on the integer grid once the delayed constant is removed, stay within ±N, and have the parity of N. The sign bit must agree with `sum_o`. The strobe must follow the input strobe by three cycles, and the outputs must hold between results. The exact value of each sum, the all-agree and all-disagree extremes, the zero case for the sign, negative and fractional constants, and the reset values are shown only by the bench's directed scenarios. Each scenario compares the outputs with a count of agreeing bits that the bench computes for itself.

// File: rtl/xnor_popcount_neuron.sv
module xnor_popcount_neuron #(
  parameter int N      = 72,
  parameter int CHUNK  = 8,
  parameter int BIAS_W = 16,
  parameter int FRAC_W = 6,
  localparam int SH_W  = $clog2(N) + 2 + FRAC_W,
  localparam int OUT_W = ((SH_W > BIAS_W) ? SH_W : BIAS_W) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              valid_i,
  input  logic [N-1:0]      act_i,
  input  logic [N-1:0]      wgt_i,
  input  logic [BIAS_W-1:0] bias_i,
  output logic              valid_o,
  output logic [OUT_W-1:0]  sum_o,
  output logic              act_o
);
  localparam int NCH = (N + CHUNK - 1) / CHUNK;
  localparam int PAD = NCH * CHUNK;
  localparam int CW  = $clog2(CHUNK + 1);
  localparam int PW  = $clog2(N + 1);

  logic [PAD-1:0]    agree;
  logic [NCH*CW-1:0] cnt_d, cnt_q;
  logic [PW-1:0]     pc_d, pc_q;
  logic [BIAS_W-1:0] b1_q, b2_q;
  logic              v1_q, v2_q;
  logic signed [OUT_W-1:0] dot, bias_x, res;

  always_comb begin
    agree = '0;
    agree[N-1:0] = ~(act_i ^ wgt_i);
  end

  always_comb begin
    cnt_d = '0;
    for (int g = 0; g < NCH; g++)
      for (int b = 0; b < CHUNK; b++)
        cnt_d[g*CW +: CW] += CW'(agree[g*CHUNK + b]);
  end

  always_comb begin
    pc_d = '0;
    for (int g = 0; g < NCH; g++)
      pc_d += PW'(cnt_q[g*CW +: CW]);
  end

  assign dot    = ((OUT_W'(pc_q) <<< 1) - OUT_W'(N)) <<< FRAC_W;
  assign bias_x = {{(OUT_W-BIAS_W){b2_q[BIAS_W-1]}}, b2_q};
  assign res    = dot + bias_x;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v1_q <= 1'b0; v2_q <= 1'b0; valid_o <= 1'b0;
      cnt_q <= '0; pc_q <= '0; b1_q <= '0; b2_q <= '0;
      sum_o <= '0; act_o <= 1'b0;
    end else begin
      v1_q    <= valid_i;
      v2_q    <= v1_q;
      valid_o <= v2_q;
      if (valid_i) begin
        cnt_q <= cnt_d;
        b1_q  <= bias_i;
      end
      if (v1_q) begin
        pc_q <= pc_d;
        b2_q <= b1_q;
      end
      if (v2_q) begin
        sum_o <= res;
        act_o <= ~res[OUT_W-1];
      end
    end
  end
endmodule

// File: rtl/xnor_popcount_neuron_chk.sv
module xnor_popcount_neuron_chk #(
  parameter int N      = 72,
  parameter int BIAS_W = 16,
  parameter int FRAC_W = 6,
  localparam int SH_W  = $clog2(N) + 2 + FRAC_W,
  localparam int OUT_W = ((SH_W > BIAS_W) ? SH_W : BIAS_W) + 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              valid_i,
  input logic [BIAS_W-1:0] bias_i,
  input logic              valid_o,
  input logic [OUT_W-1:0]  sum_o,
  input logic              act_o
);
  logic [BIAS_W-1:0] bd1, bd2, bd3;
  logic [2:0] vd;
  logic [1:0] age;
  int diff, ipart;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bd1 <= '0; bd2 <= '0; bd3 <= '0; vd <= '0; age <= '0;
    end else begin
      bd1 <= bias_i; bd2 <= bd1; bd3 <= bd2;
      vd  <= {vd[1:0], valid_i};
      if (age != 2'd3) age <= age + 2'd1;
    end
  end

  assign diff  = int'($signed(sum_o)) - int'($signed(bd3));
  assign ipart = diff >>> FRAC_W;

  // R6
  latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd3) |-> (valid_o == vd[2]));
  // R1
  grid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> ((ipart <<< FRAC_W) == diff && ipart[0] == N[0]));
  // R2
  range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> (ipart <= N && ipart >= -N));
  // R5
  sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> (act_o == ($signed(sum_o) >= 0)));
  // R8
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_o |-> ($stable(sum_o) && $stable(act_o)));
endmodule

bind xnor_popcount_neuron xnor_popcount_neuron_chk #(
  .N(N), .BIAS_W(BIAS_W), .FRAC_W(FRAC_W)
) u_chk (.*);

// File: tb/xnor_popcount_neuron_bench.sv
`timescale 1ns/1ps
module xnor_popcount_neuron_bench;
  localparam int N = 72, BW = 16, F = 6;
  localparam int OW = (($clog2(N) + 2 + F) > BW ? ($clog2(N) + 2 + F) : BW) + 1;

  logic clk = 1'b0, rst_n = 1'b0, valid_i = 1'b0;
  logic [N-1:0] act_i = '0, wgt_i = '0;
  logic [BW-1:0] bias_i = '0;
  logic valid_o, act_o;
  logic [OW-1:0] sum_o;
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  xnor_popcount_neuron #(.N(N), .BIAS_W(BW), .FRAC_W(F)) u_xnor_popcount_neuron (
    .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .act_i(act_i), .wgt_i(wgt_i),
    .bias_i(bias_i), .valid_o(valid_o), .sum_o(sum_o), .act_o(act_o));

  function automatic int ref_sum(logic [N-1:0] a, logic [N-1:0] w, logic [BW-1:0] b);
    int s = 0;
    for (int i = 0; i < N; i++) s += (a[i] == w[i]) ? 1 : -1;
    return s * (1 << F) + int'($signed(b));
  endfunction

  function automatic logic [N-1:0] rnd_vec();
    logic [95:0] t = {$urandom, $urandom, $urandom};
    return t[N-1:0];
  endfunction

  function automatic logic [N-1:0] agree_k(logic [N-1:0] a, int k);
    logic [N-1:0] w = a;
    for (int i = k; i < N; i++) w[i] = ~a[i];
    return w;
  endfunction

  task automatic chk(string req, int got, int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic t_reset();
    chk("R7 valid_o", int'(valid_o), 0);
    chk("R7 sum_o", int'($signed(sum_o)), 0);
    chk("R7 act_o", int'(act_o), 0);
  endtask

  task automatic t_single(string req, logic [N-1:0] a, logic [N-1:0] w, logic [BW-1:0] b);
    int e = ref_sum(a, w, b);
    int held;
    @(negedge clk); valid_i = 1'b1; act_i = a; wgt_i = w; bias_i = b;
    @(negedge clk); valid_i = 1'b0; act_i = rnd_vec(); wgt_i = rnd_vec(); bias_i = BW'($urandom);
    chk("R6 early", int'(valid_o), 0);
    @(negedge clk);
    chk("R6 early", int'(valid_o), 0);
    @(negedge clk);
    chk("R6 strobe", int'(valid_o), 1);
    chk(req, int'($signed(sum_o)), e);
    chk("R5 sign", int'(act_o), (e >= 0) ? 1 : 0);
    held = int'($signed(sum_o));
    @(negedge clk);
    act_i = rnd_vec(); wgt_i = rnd_vec();
    chk("R8 no strobe", int'(valid_o), 0);
    chk("R8 hold", int'($signed(sum_o)), held);
  endtask

  task automatic t_idle_hold();
    int held = int'($signed(sum_o));
    for (int c = 0; c < 6; c++) begin
      @(negedge clk);
      act_i = rnd_vec(); wgt_i = rnd_vec(); bias_i = BW'($urandom);
      chk("R8 idle strobe", int'(valid_o), 0);
      chk("R8 idle hold", int'($signed(sum_o)), held);
    end
  endtask

  task automatic t_burst();
    logic [N-1:0] a[3], w[3];
    logic [BW-1:0] b[3];
    int e[3];
    for (int k = 0; k < 3; k++) begin
      a[k] = rnd_vec(); w[k] = rnd_vec(); b[k] = BW'($urandom);
      e[k] = ref_sum(a[k], w[k], b[k]);
    end
    for (int s = 0; s < 6; s++) begin
      @(negedge clk);
      if (s >= 3) begin
        chk("R6 burst strobe", int'(valid_o), 1);
        chk("R6 burst order", int'($signed(sum_o)), e[s-3]);
      end
      if (s < 3) begin
        valid_i = 1'b1; act_i = a[s]; wgt_i = w[s]; bias_i = b[s];
      end else valid_i = 1'b0;
    end
    @(negedge clk);
    chk("R6 burst end", int'(valid_o), 0);
  endtask

  initial begin
    logic [N-1:0] r;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_single("R2 all ones", '1, '1, '0);
    t_single("R2 all zeros", '0, '0, '0);
    t_single("R3 all disagree", '1, '0, '0);
    t_single("R3 all disagree swap", '0, '1, 16'd5);
    t_single("R4 negative bias", rnd_vec(), rnd_vec(), 16'h8000);
    t_single("R4 fractional bias", rnd_vec(), rnd_vec(), 16'd37);
    r = rnd_vec();
    t_single("R5 zero sum", r, agree_k(r, N/2), '0);
    r = rnd_vec();
    t_single("R5 just negative", r, agree_k(r, N/2), 16'hFFFF);
    for (int i = 0; i < 20; i++) t_single("R1 random", rnd_vec(), rnd_vec(), BW'($urandom));
    t_idle_hold();
    t_burst();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got hang expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule